// File: doc/BRIEF.md
# Interrupt Pin Delivery and Coalescing Engine

This block holds the per-input delivery state of a 24-input interrupt router. Each input reports line events, which are assertions and deassertions of one pin. The engine records the line level of each pin. It then decides whether an assertion becomes a delivery request. That decision uses the pin's mask, its trigger mode (edge or level), the remote-IRR bit of a level pin, and a separate hold flag kept for one timer input. An accepted request carries the pin index together with the vector and destination taken from that pin's configuration. It leaves the block on a valid/ready handshake. The assertion that caused it receives a one-bit status telling whether it was actually injected.

The end-of-interrupt path takes a vector. Level pins programmed with that vector have their remote-IRR bit cleared and their resample output pulsed. If the vector belongs to the timer pin, the timer hold flag is also cleared. Every pin whose stored level is still high is then queued for re-evaluation as a fresh assertion, served lowest pin first.

A register block outside this engine owns the configuration fields. It raises a one-cycle rewrite strobe naming the pin whose entry has just changed. A rewritten level pin that is unmasked and high is serviced at once. A pin rewritten to edge mode loses its remote-IRR bit.

Top module: `irq_dlv_engine`

## Requirements
- R1: After reset every stored level, every remote-IRR bit and the timer hold flag are 0, no request is valid and no resample output is high.
- R2: An assertion on an unmasked edge pin whose stored level is low produces one request with reqPin = pin, reqVector = cfgVector[8p+7:8p], reqDest = cfgDest[8p+7:8p]. An assertion while that pin's stored level is already high is ignored, with status injected = 0. A deassertion produces no request and no status.
- R3: An assertion on a masked pin (cfgMask bit = 1) records the level high but issues no request, and its status reports injected = 0.
- R4: An accepted request on a level pin (cfgLevelTrig bit = 1) sets that pin's remote-IRR bit. While it is set, further assertions on that pin issue no request and report injected = 0.
- R5: For the timer pin (pin 8, edge mode), an accepted request sets timerHold. While timerHold is 1, assertions on pin 8 issue no request. An EOI whose vector equals pin 8's vector clears timerHold.
- R6: An accepted EOI clears remote IRR on every level pin whose vector matches. In the following cycle it raises resamplePulse for exactly those pins, for one cycle.
- R7: After an EOI, each pin whose stored level is high is re-evaluated as a fresh assertion. Re-evaluations run in ascending pin order, one pin per evaluation.
- R8: A cfgWrite strobe for a level pin that is unmasked with its level high services that pin at once. A cfgWrite for a pin now in edge mode clears its remote IRR.
- R9: statValid pulses once for each line assertion. statInjected is 1 only when the resulting request was accepted. Re-evaluations and deassertions report no status.
- R10: While reqValid is high and reqReady is low, reqPin, reqVector and reqDest hold, and no line event or EOI is accepted.
- R11: Work is taken in fixed priority: EOI first, then a line event, then a pending re-evaluation. A line event offered together with an EOI is not accepted in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lineValid | input | 1 | Line event offered |
| linePin | input | 5 | Pin of the line event |
| lineLevel | input | 1 | 1 = assert, 0 = deassert |
| lineReady | output | 1 | Line event taken this cycle |
| eoiValid | input | 1 | End-of-interrupt offered |
| eoiVector | input | 8 | Vector being retired |
| eoiReady | output | 1 | EOI taken this cycle |
| cfgMask | input | 24 | Per-pin mask |
| cfgLevelTrig | input | 24 | Per-pin trigger mode, 1 = level |
| cfgVector | input | 192 | Per-pin vector, pin p at bits 8p+7:8p |
| cfgDest | input | 192 | Per-pin destination, pin p at bits 8p+7:8p |
| cfgWrite | input | 1 | Entry of cfgWritePin was just rewritten |
| cfgWritePin | input | 5 | Pin whose entry was rewritten |
| reqValid | output | 1 | Delivery request valid |
| reqReady | input | 1 | Downstream accepts request |
| reqPin | output | 5 | Requesting pin |
| reqVector | output | 8 | Vector of the request |
| reqDest | output | 8 | Destination of the request |
| statValid | output | 1 | Status of a line assertion is valid |
| statInjected | output | 1 | 1 = assertion was delivered |
| resamplePulse | output | 24 | One-cycle per-pin resample strobe after EOI |
| remoteIrr | output | 24 | Remote-IRR bits, for read-back by the register block |
| timerHold | output | 1 | Timer-pin coalescing flag |

## Verification
The assertions assume that the register block changes cfgMask, cfgLevelTrig and the vectors only together with a cfgWrite strobe or while no request is pending. They also assume that linePin and cfgWritePin stay below 24, and that reqReady is eventually granted. The stimulus keeps within these limits. It updates configuration in the cycle before any rewrite strobe, uses only pins 0 to 23, and gives each pin a distinct vector except where two pins deliberately share one. It holds reqReady low only for a bounded stretch.

// File: rtl/irq_dlv_pkg.sv
package irq_dlv_pkg;
  // Strobes from the control FSM into the state datapath.
  typedef struct packed {
    logic eoiApply;   // retire the EOI vector this cycle
    logic setLevel;   // record selected pin level high
    logic clrLevel;   // record selected pin level low
    logic rescanClr;  // drop selected pin from re-evaluation set
    logic reqLoad;    // capture selected pin into the request register
    logic reqAccept;  // request handshake completed
  } dlvStrobes_t;
endpackage

// File: rtl/irq_dlv_datapath.sv
module irq_dlv_datapath
  import irq_dlv_pkg::*;
#(
  parameter int N         = 24,
  parameter int TIMER_PIN = 8,
  parameter int VEC_W     = 8,
  parameter int DEST_W    = 8,
  localparam int PIN_W    = $clog2(N)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  dlvStrobes_t         st,
  input  logic [PIN_W-1:0]    selPin,
  input  logic [VEC_W-1:0]    eoiVector,
  input  logic [N-1:0]        cfgMask,
  input  logic [N-1:0]        cfgLevelTrig,
  input  logic [N*VEC_W-1:0]  cfgVector,
  input  logic [N*DEST_W-1:0] cfgDest,
  input  logic                cfgWrite,
  input  logic [PIN_W-1:0]    cfgWritePin,
  output logic                selEdgeHigh,
  output logic                selBlocked,
  output logic                rescanAny,
  output logic [PIN_W-1:0]    rescanPin,
  output logic [N-1:0]        remoteIrr,
  output logic                timerHold,
  output logic [N-1:0]        resamplePulse,
  output logic [PIN_W-1:0]    reqPin,
  output logic [VEC_W-1:0]    reqVector,
  output logic [DEST_W-1:0]   reqDest
);
  logic [VEC_W-1:0]  vecArr  [N];
  logic [DEST_W-1:0] destArr [N];
  logic [N-1:0]      eoiHit;
  logic [N-1:0]      levelQ, levelNxt;
  logic [N-1:0]      irrNxt;
  logic [N-1:0]      rescanQ, rescanNxt;
  logic              timerBlock;

  for (genvar g = 0; g < N; g++) begin : g_pin
    assign vecArr[g]  = cfgVector[g*VEC_W +: VEC_W];
    assign destArr[g] = cfgDest[g*DEST_W +: DEST_W];
    assign eoiHit[g]  = (vecArr[g] == eoiVector);
  end

  // Timer coalescing flag exists only when the timer pin is in range.
  if (TIMER_PIN < N) begin : g_timer
    logic holdQ;
    always_ff @(posedge clk) begin
      if (!rst_n) holdQ <= 1'b0;
      else if (st.eoiApply && eoiHit[TIMER_PIN]) holdQ <= 1'b0;
      else if (st.reqAccept && reqPin == PIN_W'(TIMER_PIN) && !cfgLevelTrig[TIMER_PIN])
        holdQ <= 1'b1;
    end
    assign timerHold  = holdQ;
    assign timerBlock = holdQ && (selPin == PIN_W'(TIMER_PIN));
  end else begin : g_no_timer
    assign timerHold  = 1'b0;
    assign timerBlock = 1'b0;
  end

  // Evaluation of the selected pin.
  assign selEdgeHigh = !cfgLevelTrig[selPin] && levelQ[selPin];
  assign selBlocked  = cfgMask[selPin] || (cfgLevelTrig[selPin] && remoteIrr[selPin]) ||
                       timerBlock;

  // Lowest pending re-evaluation wins.
  always_comb begin
    rescanAny = 1'b0;
    rescanPin = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (rescanQ[i]) begin
        rescanAny = 1'b1;
        rescanPin = PIN_W'(i);
      end
    end
  end

  always_comb begin
    levelNxt = levelQ;
    if (st.setLevel) levelNxt[selPin] = 1'b1;
    if (st.clrLevel) levelNxt[selPin] = 1'b0;

    irrNxt = remoteIrr;
    if (st.eoiApply) irrNxt = irrNxt & ~(eoiHit & cfgLevelTrig);
    if (st.reqAccept && cfgLevelTrig[reqPin]) irrNxt[reqPin] = 1'b1;
    if (cfgWrite && !cfgLevelTrig[cfgWritePin]) irrNxt[cfgWritePin] = 1'b0;

    rescanNxt = rescanQ;
    if (st.rescanClr) rescanNxt[selPin] = 1'b0;
    if (st.eoiApply) rescanNxt = rescanNxt | levelQ;
    if (cfgWrite && cfgLevelTrig[cfgWritePin] && !cfgMask[cfgWritePin] &&
        levelQ[cfgWritePin])
      rescanNxt[cfgWritePin] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      levelQ        <= '0;
      remoteIrr     <= '0;
      rescanQ       <= '0;
      resamplePulse <= '0;
      reqPin        <= '0;
      reqVector     <= '0;
      reqDest       <= '0;
    end else begin
      levelQ        <= levelNxt;
      remoteIrr     <= irrNxt;
      rescanQ       <= rescanNxt;
      resamplePulse <= st.eoiApply ? (eoiHit & cfgLevelTrig) : '0;
      if (st.reqLoad) begin
        reqPin    <= selPin;
        reqVector <= vecArr[selPin];
        reqDest   <= destArr[selPin];
      end
    end
  end
endmodule

// File: rtl/irq_dlv_control.sv
module irq_dlv_control
  import irq_dlv_pkg::*;
#(
  parameter int N      = 24,
  localparam int PIN_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eoiValid,
  output logic             eoiReady,
  input  logic             lineValid,
  input  logic [PIN_W-1:0] linePin,
  input  logic             lineLevel,
  output logic             lineReady,
  input  logic             rescanAny,
  input  logic [PIN_W-1:0] rescanPin,
  input  logic             selEdgeHigh,
  input  logic             selBlocked,
  input  logic             reqReady,
  output logic             reqValid,
  output dlvStrobes_t      st,
  output logic [PIN_W-1:0] selPin,
  output logic             statValid,
  output logic             statInjected
);
  typedef enum logic {S_IDLE, S_SEND} ctlState_t;
  ctlState_t stateQ, stateNxt;
  logic srcLineQ, srcLineNxt;
  logic statSet, statInj;

  always_comb begin
    st         = '0;
    stateNxt   = stateQ;
    srcLineNxt = srcLineQ;
    selPin     = linePin;
    eoiReady   = 1'b0;
    lineReady  = 1'b0;
    statSet    = 1'b0;
    statInj    = 1'b0;
    unique case (stateQ)
      S_IDLE: begin
        if (eoiValid) begin
          eoiReady    = 1'b1;
          st.eoiApply = 1'b1;
        end else if (lineValid) begin
          lineReady = 1'b1;
          if (!lineLevel) begin
            st.clrLevel = 1'b1;
          end else if (selEdgeHigh) begin
            statSet = 1'b1;
          end else begin
            st.setLevel = 1'b1;
            if (selBlocked) begin
              statSet = 1'b1;
            end else begin
              st.reqLoad = 1'b1;
              srcLineNxt = 1'b1;
              stateNxt   = S_SEND;
            end
          end
        end else if (rescanAny) begin
          selPin       = rescanPin;
          st.rescanClr = 1'b1;
          if (!selEdgeHigh && !selBlocked) begin
            st.setLevel = 1'b1;
            st.reqLoad  = 1'b1;
            srcLineNxt  = 1'b0;
            stateNxt    = S_SEND;
          end
        end
      end
      S_SEND: begin
        if (reqReady) begin
          st.reqAccept = 1'b1;
          stateNxt     = S_IDLE;
          if (srcLineQ) begin
            statSet = 1'b1;
            statInj = 1'b1;
          end
        end
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  assign reqValid = (stateQ == S_SEND);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stateQ       <= S_IDLE;
      srcLineQ     <= 1'b0;
      statValid    <= 1'b0;
      statInjected <= 1'b0;
    end else begin
      stateQ       <= stateNxt;
      srcLineQ     <= srcLineNxt;
      statValid    <= statSet;
      statInjected <= statInj;
    end
  end
endmodule

// File: rtl/irq_dlv_engine.sv
module irq_dlv_engine
  import irq_dlv_pkg::*;
#(
  parameter int N         = 24,
  parameter int TIMER_PIN = 8,
  parameter int VEC_W     = 8,
  parameter int DEST_W    = 8,
  localparam int PIN_W    = $clog2(N)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lineValid,
  input  logic [PIN_W-1:0]    linePin,
  input  logic                lineLevel,
  output logic                lineReady,
  input  logic                eoiValid,
  input  logic [VEC_W-1:0]    eoiVector,
  output logic                eoiReady,
  input  logic [N-1:0]        cfgMask,
  input  logic [N-1:0]        cfgLevelTrig,
  input  logic [N*VEC_W-1:0]  cfgVector,
  input  logic [N*DEST_W-1:0] cfgDest,
  input  logic                cfgWrite,
  input  logic [PIN_W-1:0]    cfgWritePin,
  output logic                reqValid,
  input  logic                reqReady,
  output logic [PIN_W-1:0]    reqPin,
  output logic [VEC_W-1:0]    reqVector,
  output logic [DEST_W-1:0]   reqDest,
  output logic                statValid,
  output logic                statInjected,
  output logic [N-1:0]        resamplePulse,
  output logic [N-1:0]        remoteIrr,
  output logic                timerHold
);
  dlvStrobes_t      st;
  logic [PIN_W-1:0] selPin, rescanPin;
  logic             selEdgeHigh, selBlocked, rescanAny;

  irq_dlv_control #(.N(N)) ctl_i (
    .clk(clk), .rst_n(rst_n),
    .eoiValid(eoiValid), .eoiReady(eoiReady),
    .lineValid(lineValid), .linePin(linePin), .lineLevel(lineLevel), .lineReady(lineReady),
    .rescanAny(rescanAny), .rescanPin(rescanPin),
    .selEdgeHigh(selEdgeHigh), .selBlocked(selBlocked),
    .reqReady(reqReady), .reqValid(reqValid),
    .st(st), .selPin(selPin),
    .statValid(statValid), .statInjected(statInjected)
  );

  irq_dlv_datapath #(.N(N), .TIMER_PIN(TIMER_PIN), .VEC_W(VEC_W), .DEST_W(DEST_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .st(st), .selPin(selPin), .eoiVector(eoiVector),
    .cfgMask(cfgMask), .cfgLevelTrig(cfgLevelTrig), .cfgVector(cfgVector), .cfgDest(cfgDest),
    .cfgWrite(cfgWrite), .cfgWritePin(cfgWritePin),
    .selEdgeHigh(selEdgeHigh), .selBlocked(selBlocked),
    .rescanAny(rescanAny), .rescanPin(rescanPin),
    .remoteIrr(remoteIrr), .timerHold(timerHold), .resamplePulse(resamplePulse),
    .reqPin(reqPin), .reqVector(reqVector), .reqDest(reqDest)
  );
endmodule

// File: rtl/irq_dlv_checker.sv
module irq_dlv_checker #(
  parameter int N         = 24,
  parameter int TIMER_PIN = 8,
  parameter int VEC_W     = 8,
  parameter int DEST_W    = 8,
  localparam int PIN_W    = $clog2(N)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lineReady,
  input logic              eoiValid,
  input logic              eoiReady,
  input logic [N-1:0]      cfgMask,
  input logic [N-1:0]      cfgLevelTrig,
  input logic              cfgWrite,
  input logic              reqValid,
  input logic              reqReady,
  input logic [PIN_W-1:0]  reqPin,
  input logic [VEC_W-1:0]  reqVector,
  input logic [DEST_W-1:0] reqDest,
  input logic              statValid,
  input logic              statInjected,
  input logic [N-1:0]      resamplePulse,
  input logic [N-1:0]      remoteIrr,
  input logic              timerHold
);
  logic [N-1:0] maskPrev, trigPrev, irrPrev;
  always_ff @(posedge clk) begin
    maskPrev <= cfgMask;
    trigPrev <= cfgLevelTrig;
    irrPrev  <= remoteIrr;
  end

  a_r3_masked_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reqValid) |-> !maskPrev[reqPin]);

  a_r4_irr_coalesce: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reqValid) |-> !(trigPrev[reqPin] && irrPrev[reqPin]));

  a_r4_irr_set: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqReady && cfgLevelTrig[reqPin] && !cfgWrite) |=> remoteIrr[$past(reqPin)]);

  a_r5_timer_set: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqReady && reqPin == PIN_W'(TIMER_PIN) && !cfgLevelTrig[TIMER_PIN])
      |=> timerHold);

  a_r6_resample_after_eoi: assert property (@(posedge clk) disable iff (!rst_n)
    (|resamplePulse) |-> $past(eoiValid && eoiReady));

  a_r9_status_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (statValid && statInjected) |-> $past(reqValid && reqReady));

  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && !reqReady) |=> (reqValid && $stable(reqPin) && $stable(reqVector) &&
                                 $stable(reqDest)));

  a_r10_no_take_busy: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |-> (!lineReady && !eoiReady));

  a_r11_eoi_first: assert property (@(posedge clk) disable iff (!rst_n)
    eoiValid |-> !lineReady);
endmodule

bind irq_dlv_engine irq_dlv_checker #(
  .N(N), .TIMER_PIN(TIMER_PIN), .VEC_W(VEC_W), .DEST_W(DEST_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .lineReady(lineReady), .eoiValid(eoiValid), .eoiReady(eoiReady),
  .cfgMask(cfgMask), .cfgLevelTrig(cfgLevelTrig), .cfgWrite(cfgWrite),
  .reqValid(reqValid), .reqReady(reqReady), .reqPin(reqPin), .reqVector(reqVector),
  .reqDest(reqDest), .statValid(statValid), .statInjected(statInjected),
  .resamplePulse(resamplePulse), .remoteIrr(remoteIrr), .timerHold(timerHold)
);

// File: tb/irq_dlv_engine_tb.sv
`timescale 1ns/1ps
module irq_dlv_engine_tb_top;
  localparam int N = 24;
  localparam int TP = 8;

  logic clk = 0, rst_n = 0;
  logic lineValid = 0, lineLevel = 0, eoiValid = 0, cfgWrite = 0, reqReady = 1;
  logic [4:0] linePin = 0, cfgWritePin = 0;
  logic [7:0] eoiVector = 0;
  logic [N-1:0] maskR = 0, trigR = 0;
  logic [N*8-1:0] vecF, destF;
  logic lineReady, eoiReady, reqValid, statValid, statInjected, timerHold;
  logic [4:0] reqPin;
  logic [7:0] reqVector, reqDest;
  logic [N-1:0] resamplePulse, remoteIrr;

  always #10 clk = ~clk;

  irq_dlv_engine dut_i (
    .clk(clk), .rst_n(rst_n), .lineValid(lineValid), .linePin(linePin), .lineLevel(lineLevel),
    .lineReady(lineReady), .eoiValid(eoiValid), .eoiVector(eoiVector), .eoiReady(eoiReady),
    .cfgMask(maskR), .cfgLevelTrig(trigR), .cfgVector(vecF), .cfgDest(destF),
    .cfgWrite(cfgWrite), .cfgWritePin(cfgWritePin), .reqValid(reqValid), .reqReady(reqReady),
    .reqPin(reqPin), .reqVector(reqVector), .reqDest(reqDest), .statValid(statValid),
    .statInjected(statInjected), .resamplePulse(resamplePulse), .remoteIrr(remoteIrr),
    .timerHold(timerHold)
  );

  int checks = 0, errors = 0;
  int reqCnt = 0, statCnt = 0;
  logic [4:0] lastPin, reqLog [64];
  logic [7:0] lastVec, lastDest;
  logic lastInj = 0;
  logic [N-1:0] resSeen = 0;
  bit finished = 0;

  always @(negedge clk) if (rst_n) begin
    if (reqValid && reqReady) begin
      lastPin = reqPin; lastVec = reqVector; lastDest = reqDest;
      reqLog[reqCnt % 64] = reqPin;
      reqCnt++;
    end
    if (statValid) begin statCnt++; lastInj = statInjected; end
    resSeen = resSeen | resamplePulse;
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitN(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic lineEv(int p, bit lvl);
    @(posedge clk); #1 lineValid = 1; linePin = 5'(p); lineLevel = lvl;
    do @(negedge clk); while (!lineReady);
    @(posedge clk); #1 lineValid = 0;
  endtask

  task automatic eoi(logic [7:0] v);
    @(posedge clk); #1 eoiValid = 1; eoiVector = v;
    do @(negedge clk); while (!eoiReady);
    @(posedge clk); #1 eoiValid = 0;
  endtask

  task automatic cfgWr(int p);
    @(posedge clk); #1 cfgWrite = 1; cfgWritePin = 5'(p);
    @(posedge clk); #1 cfgWrite = 0;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    if (!finished) $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int r0, s0;
    for (int p = 0; p < N; p++) begin
      vecF[p*8 +: 8]  = 8'(8'h20 + p);
      destF[p*8 +: 8] = 8'(8'h80 + p);
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 reqValid", reqValid, 0);
    check("R1 remoteIrr", remoteIrr, 0);
    check("R1 timerHold", timerHold, 0);
    check("R1 resample", resamplePulse, 0);

    // R2/R9 sweep over every edge pin
    for (int p = 0; p < N; p++) begin
      r0 = reqCnt; s0 = statCnt;
      lineEv(p, 1); waitN(4);
      check("R2 one request", reqCnt - r0, 1);
      check("R2 pin", lastPin, p);
      check("R2 vector", lastVec, 8'h20 + p);
      check("R2 dest", lastDest, 8'h80 + p);
      check("R9 status count", statCnt - s0, 1);
      check("R9 injected", lastInj, 1);
      if (p == TP) check("R5 hold set", timerHold, 1);
      lineEv(p, 1); waitN(4);
      check("R2 repeat ignored", reqCnt - r0, 1);
      check("R2 repeat status", lastInj, 0);
      s0 = statCnt;
      lineEv(p, 0); waitN(4);
      check("R2 deassert no req", reqCnt - r0, 1);
      check("R9 deassert no status", statCnt - s0, 0);
    end

    // R3 masked pin
    @(posedge clk); #1 maskR[3] = 1;
    r0 = reqCnt;
    lineEv(3, 1); waitN(4);
    check("R3 masked no req", reqCnt - r0, 0);
    check("R3 masked status", lastInj, 0);
    @(posedge clk); #1 maskR[3] = 0;
    lineEv(3, 1); waitN(4);
    check("R3 level recorded", reqCnt - r0, 0);
    lineEv(3, 0);

    // R4 / R6 / R7 level pin 5
    @(posedge clk); #1 trigR[5] = 1;
    cfgWr(5);
    r0 = reqCnt;
    lineEv(5, 1); waitN(4);
    check("R4 level delivered", reqCnt - r0, 1);
    check("R4 irr set", remoteIrr[5], 1);
    lineEv(5, 0); lineEv(5, 1); waitN(4);
    check("R4 coalesced", reqCnt - r0, 1);
    check("R4 coalesced status", lastInj, 0);
    resSeen = 0;
    eoi(8'h25); waitN(6);
    check("R6 resample pin5", resSeen, 24'h000020);
    check("R7 reinjected", reqCnt - r0, 2);
    check("R7 reinjected pin", lastPin, 5);
    check("R4 irr set again", remoteIrr[5], 1);
    lineEv(5, 0);
    eoi(8'h25); waitN(6);
    check("R6 irr cleared", remoteIrr[5], 0);
    check("R7 low no reinject", reqCnt - r0, 2);

    // R5 timer pin
    r0 = reqCnt;
    lineEv(TP, 1); waitN(4);
    check("R5 dropped while held", reqCnt - r0, 0);
    eoi(8'h28); waitN(6);
    check("R5 hold cleared", timerHold, 0);
    check("R7 edge high not reinjected", reqCnt - r0, 0);
    lineEv(TP, 0); lineEv(TP, 1); waitN(4);
    check("R5 delivered after clear", reqCnt - r0, 1);
    check("R5 hold set again", timerHold, 1);
    lineEv(TP, 0);

    // R8 rewrite services high level pin
    @(posedge clk); #1 trigR[10] = 1; maskR[10] = 1;
    cfgWr(10);
    r0 = reqCnt; s0 = statCnt;
    lineEv(10, 1); waitN(4);
    check("R3 masked level pin", reqCnt - r0, 0);
    s0 = statCnt;
    @(posedge clk); #1 maskR[10] = 0;
    cfgWr(10); waitN(4);
    check("R8 serviced on rewrite", reqCnt - r0, 1);
    check("R8 pin", lastPin, 10);
    check("R9 no status for rewrite", statCnt - s0, 0);
    lineEv(10, 0); eoi(8'h2A); waitN(4);

    // R10 backpressure
    @(posedge clk); #1 trigR[12] = 1; reqReady = 0;
    cfgWr(12);
    r0 = reqCnt;
    lineEv(12, 1); waitN(5);
    check("R10 held valid", reqValid, 1);
    check("R10 held pin", reqPin, 12);
    check("R10 held vector", reqVector, 8'h2C);
    @(posedge clk); #1 eoiValid = 1; eoiVector = 8'h2C;
    waitN(3);
    check("R10 eoi stalled", eoiReady, 0);
    @(posedge clk); #1 reqReady = 1;
    do @(negedge clk); while (!eoiReady);
    @(posedge clk); #1 eoiValid = 0;
    waitN(6);
    check("R10 accepted then reinjected", reqCnt - r0, 2);
    lineEv(12, 0); eoi(8'h2C); waitN(4);

    // R11 priority
    @(posedge clk); #1 eoiValid = 1; eoiVector = 8'h99;
    lineValid = 1; linePin = 20; lineLevel = 1;
    @(negedge clk);
    check("R11 eoi taken", eoiReady, 1);
    check("R11 line waits", lineReady, 0);
    @(posedge clk); #1 eoiValid = 0;
    do @(negedge clk); while (!lineReady);
    @(posedge clk); #1 lineValid = 0;
    waitN(4);
    check("R11 line later served", lastPin, 20);
    lineEv(20, 0);

    // R7 ascending order with a shared vector
    @(posedge clk); #1 trigR[14] = 1; trigR[15] = 1;
    vecF[14*8 +: 8] = 8'h50; vecF[15*8 +: 8] = 8'h50;
    cfgWr(14); cfgWr(15);
    lineEv(15, 1); lineEv(14, 1); waitN(4);
    r0 = reqCnt; resSeen = 0;
    eoi(8'h50); waitN(8);
    check("R7 two reinjections", reqCnt - r0, 2);
    check("R7 first lower pin", reqLog[r0 % 64], 14);
    check("R7 second higher pin", reqLog[(r0 + 1) % 64], 15);
    check("R6 resample shared", resSeen, 24'h00C000);

    // R8 switch to edge clears irr
    @(posedge clk); #1 trigR[14] = 0;
    cfgWr(14); waitN(3);
    check("R8 edge clears irr", remoteIrr[14], 0);
    check("R8 other irr kept", remoteIrr[15], 1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule